// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sorts interrupt requests into eight priority levels and hands the processor a trap vector for the request that wins. Level 0 is the most urgent. Levels 0 to 3 carry hardware device requests, and up to eight devices share each of these levels. Levels 4 to 7 carry requests raised by software. A level that has been granted stays marked as in service until the processor dismisses it. A pending request wins only when its level is more urgent than every level already in service, so urgent work preempts less urgent work, and nested service follows naturally.

The processor sees `brk_req` whenever a break should be taken. It answers with a one-cycle `brk_ack`. One cycle later the block issues a one-cycle grant. A hardware device receives a strobe on its own `dev_grant` line and answers, during that same cycle, by placing its vector on `dev_vec_in`. The block forwards that vector on `brk_vec`. A software level gets a fixed vector instead. One command turns the whole system on or off. A power-clear input wipes all state.

Top module: `prio_vec_intc`

## Requirements
- R1: A low `rst_n` at a clock edge, or a high `pwr_clr`, clears the global enable, every software pending bit and every in-service bit, and removes any grant. After either one, `brk_req` stays low until the enable command is given again.
- R2: A cycle with `en_cmd_valid` high loads `en_cmd_value` into the global enable. While the enable is off, `brk_req` stays low. Pending requests are kept and are raised once the enable is back on.
- R3: Level L (0 to 3) is pending while any of `dev_req[8L+7:8L]` is high. Software level S is level 4+S. It becomes pending on a one-cycle `sw_set[S]` pulse and stays pending until it is granted. `brk_level` reports the granted level, where 0 is the most urgent.
- R4: `brk_req` is high exactly when the enable is on and the most urgent pending level is more urgent than every in-service level. With nothing in service, any pending level qualifies.
- R5: A `brk_ack` taken while `brk_req` is high produces the following in the next cycle, each for one cycle: `vec_valid`, `brk_level` and `brk_vec`. From that cycle on, the in-service bit of the granted level (`in_service[L]`) is set.
- R6: Within one hardware level, the lowest-numbered requesting slot wins. Only that device's bit in `dev_grant` (index 8L+slot) pulses, and at most one bit of `dev_grant` is ever high.
- R7: For a hardware grant, `brk_vec` equals `dev_vec_in` in the grant cycle. For software level S, `brk_vec` is octal 74+S (octal 74 to 77) and no `dev_grant` bit rises. A software grant clears that level's pending bit.
- R8: A `dismiss` pulse clears the most urgent in-service bit. With nothing in service, it has no effect.
- R9: A hardware request at a more urgent level than the one in service raises `brk_req`, and its grant adds a second in-service bit.
- R10: A `brk_ack` while `brk_req` is low is ignored: no grant appears and `in_service` is unchanged.
- R11: When `brk_ack` (with `brk_req` high) and `dismiss` fall in the same cycle, both take effect. The most urgent bit that was in service before the edge is cleared, and the bit of the newly granted level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_clr | input | 1 | Power-clear: synchronous wipe of all state |
| en_cmd_valid | input | 1 | Global enable command strobe |
| en_cmd_value | input | 1 | 1 enables, 0 disables the system |
| dev_req | input | 32 | Device requests, bit 8*level+slot |
| sw_set | input | 4 | One-cycle software request pulses, levels 4 to 7 |
| brk_ack | input | 1 | Processor accepts the break |
| dismiss | input | 1 | Processor ends the most urgent service |
| dev_vec_in | input | 6 | Vector posted by the granted device |
| brk_req | output | 1 | Break wanted |
| vec_valid | output | 1 | Grant cycle marker |
| brk_level | output | 3 | Granted level |
| brk_vec | output | 6 | Trap vector, address bits 12 to 17 |
| dev_grant | output | 32 | One-hot grant strobe to the winning device |
| in_service | output | 8 | In-service bit per level |

## Verification
The two operations that can land on the same edge are a break acceptance and a dismiss. The bench provokes this by requesting a more urgent level while a less urgent one is in service, then pulsing `brk_ack` and `dismiss` together. The expected `in_service` must show the old most-urgent bit removed and the new level added. A long random phase throws acknowledges, dismisses, software pulses, enable commands and power-clears at a behavioural model, so these collisions also arise in many other combinations. Every output is compared with the model on each clock.

// File: rtl/pvi_pkg.sv
// Package: default sizing shared by the controller and its sub-blocks.
// Assumes: device slots per level and level counts are powers of two.
package pvi_pkg;
    localparam int DEF_HW_LEVELS   = 4;
    localparam int DEF_SW_LEVELS   = 4;
    localparam int DEF_SLOTS       = 8;
    localparam int DEF_VEC_W       = 6;
    localparam int DEF_SW_VEC_BASE = 'o74;
endpackage

// File: rtl/pic_level_chain.sv
// Module: fixed-order chain among the devices sharing one hardware level.
// Reports whether any slot requests, and which slot wins (the lowest index).
// Assumes: SLOTS >= 2.
module pic_level_chain #(
    parameter int SLOTS = 8
) (
    input  logic [SLOTS-1:0]         req,
    output logic                     hit,
    output logic [$clog2(SLOTS)-1:0] winner
);
    localparam int SW = $clog2(SLOTS);

    logic [SLOTS:0]   blocked;
    logic [SLOTS-1:0] take;

    assign blocked[0] = 1'b0;
    for (genvar g = 0; g < SLOTS; g++) begin : g_link
        // each link passes only if no earlier slot requested
        assign take[g]        = req[g] & ~blocked[g];
        assign blocked[g + 1] = blocked[g] | req[g];
    end
    assign hit = blocked[SLOTS];

    // encode the single winning slot
    always_comb begin
        winner = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (take[i]) winner = SW'(i);
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// Module: compares the most urgent pending level with the most urgent level in
// service and decides whether a break is wanted. Level 0 is most urgent.
// Assumes: LEVELS >= 2.
module pic_resolver #(
    parameter int LEVELS = 8
) (
    input  logic                      enable,
    input  logic [LEVELS-1:0]         pend,
    input  logic [LEVELS-1:0]         in_svc,
    output logic                      want,
    output logic [$clog2(LEVELS)-1:0] win_lvl
);
    localparam int LW = $clog2(LEVELS);

    int p_idx;
    int q_idx;

    // find both top levels, then gate the request on enable and rank
    always_comb begin
        p_idx = LEVELS;
        q_idx = LEVELS;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (pend[i])   p_idx = i;
            if (in_svc[i]) q_idx = i;
        end
        want    = enable && (p_idx < q_idx);
        win_lvl = LW'(p_idx);
    end
endmodule

// File: rtl/pic_svc_track.sv
// Module: in-service register, one bit per level. A grant sets the bit of its
// level; a dismiss clears the most urgent set bit; both may happen at once.
// Assumes: set_lvl is only meaningful while set_en is high.
module pic_svc_track #(
    parameter int LEVELS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      set_en,
    input  logic [$clog2(LEVELS)-1:0] set_lvl,
    input  logic                      dismiss,
    output logic [LEVELS-1:0]         in_svc
);
    logic [LEVELS-1:0] low_bit;
    logic [LEVELS-1:0] set_mask;

    // isolate the most urgent in-service bit and decode the new level
    always_comb begin
        low_bit = in_svc & (~in_svc + LEVELS'(1));
        for (int i = 0; i < LEVELS; i++) begin
            set_mask[i] = set_en && (int'(set_lvl) == i);
        end
    end

    // update the in-service register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) in_svc <= '0;
        else               in_svc <= (in_svc & ~(dismiss ? low_bit : '0)) | set_mask;
    end

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_svc == '0));
    assert_grant_marks_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr) |=> in_svc[$past(set_lvl)]);
    assert_dismiss_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dismiss && !set_en && !clr && (in_svc != '0))
        |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
    assert_no_growth_without_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr) |=> ((in_svc & ~$past(in_svc)) == '0));
endmodule

// File: rtl/prio_vec_intc.sv
// Module: vectored priority interrupt controller. Hardware levels come first
// (most urgent), software levels follow. Holds the global enable and the
// software pending bits, and registers the grant that answers a break ack.
// Assumes: the granted device drives dev_vec_in while its dev_grant is high.
module prio_vec_intc
    import pvi_pkg::*;
#(
    parameter int HW_LEVELS   = DEF_HW_LEVELS,
    parameter int SW_LEVELS   = DEF_SW_LEVELS,
    parameter int SLOTS       = DEF_SLOTS,
    parameter int VEC_W       = DEF_VEC_W,
    parameter int SW_VEC_BASE = DEF_SW_VEC_BASE
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pwr_clr,
    input  logic                                 en_cmd_valid,
    input  logic                                 en_cmd_value,
    input  logic [HW_LEVELS*SLOTS-1:0]           dev_req,
    input  logic [SW_LEVELS-1:0]                 sw_set,
    input  logic                                 brk_ack,
    input  logic                                 dismiss,
    input  logic [VEC_W-1:0]                     dev_vec_in,
    output logic                                 brk_req,
    output logic                                 vec_valid,
    output logic [$clog2(HW_LEVELS+SW_LEVELS)-1:0] brk_level,
    output logic [VEC_W-1:0]                     brk_vec,
    output logic [HW_LEVELS*SLOTS-1:0]           dev_grant,
    output logic [HW_LEVELS+SW_LEVELS-1:0]       in_service
);
    localparam int LEVELS = HW_LEVELS + SW_LEVELS;
    localparam int LW     = $clog2(LEVELS);
    localparam int SLW    = $clog2(SLOTS);
    localparam int CH     = HW_LEVELS * SLOTS;
    localparam int CHW    = $clog2(CH);

    logic [LEVELS-1:0]    pend;
    logic [SLW-1:0]       lvl_slot [LEVELS];
    logic [LW-1:0]        win_lvl;
    logic                 grant;
    logic                 en_q;
    logic [SW_LEVELS-1:0] sw_pend;
    logic [SW_LEVELS-1:0] sw_take;
    logic [LW-1:0]        g_lvl;
    logic [CHW-1:0]       g_ch;
    logic                 g_hw;

    for (genvar l = 0; l < HW_LEVELS; l++) begin : g_hw_lvl
        pic_level_chain #(.SLOTS(SLOTS)) u_chain (
            .req    (dev_req[l*SLOTS +: SLOTS]),
            .hit    (pend[l]),
            .winner (lvl_slot[l])
        );
    end
    for (genvar s = 0; s < SW_LEVELS; s++) begin : g_sw_lvl
        assign pend[HW_LEVELS + s]     = sw_pend[s];
        assign lvl_slot[HW_LEVELS + s] = '0;
    end

    pic_resolver #(.LEVELS(LEVELS)) u_resolve (
        .enable  (en_q),
        .pend    (pend),
        .in_svc  (in_service),
        .want    (brk_req),
        .win_lvl (win_lvl)
    );

    assign grant = brk_ack && brk_req;

    pic_svc_track #(.LEVELS(LEVELS)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_clr),
        .set_en  (grant),
        .set_lvl (win_lvl),
        .dismiss (dismiss),
        .in_svc  (in_service)
    );

    // which software pending bit the current grant consumes
    always_comb begin
        for (int s = 0; s < SW_LEVELS; s++) begin
            sw_take[s] = grant && (int'(win_lvl) == HW_LEVELS + s);
        end
    end

    // enable, software pending and the registered grant record
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_clr) begin
            en_q      <= 1'b0;
            sw_pend   <= '0;
            vec_valid <= 1'b0;
            g_lvl     <= '0;
            g_ch      <= '0;
            g_hw      <= 1'b0;
        end else begin
            if (en_cmd_valid) en_q <= en_cmd_value;
            sw_pend   <= (sw_pend & ~sw_take) | sw_set;
            vec_valid <= grant;
            g_lvl     <= win_lvl;
            g_ch      <= CHW'(int'(win_lvl) * SLOTS + int'(lvl_slot[win_lvl]));
            g_hw      <= int'(win_lvl) < HW_LEVELS;
        end
    end

    // one-hot strobe to the winning device during the grant cycle
    always_comb begin
        for (int c = 0; c < CH; c++) begin
            dev_grant[c] = vec_valid && g_hw && (int'(g_ch) == c);
        end
    end

    // vector: forwarded from the device, or fixed for a software level
    always_comb begin
        if (!vec_valid) brk_vec = '0;
        else if (g_hw)  brk_vec = dev_vec_in;
        else            brk_vec = VEC_W'(SW_VEC_BASE + int'(g_lvl) - HW_LEVELS);
    end
    assign brk_level = g_lvl;

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_grant));
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !brk_req);
    assert_grant_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(brk_ack && brk_req));
    assert_sw_grant_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !g_hw) |-> (dev_grant == '0));
endmodule

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
    localparam int HWL = 4, SWL = 4, SL = 8, LV = 8, CH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, pwr_clr = 1'b0, en_cmd_valid = 1'b0, en_cmd_value = 1'b0;
    logic [31:0] dev_req = '0;
    logic [3:0]  sw_set = '0;
    logic        brk_ack = 1'b0, dismiss = 1'b0;
    logic [5:0]  dev_vec_in;
    logic        brk_req, vec_valid;
    logic [2:0]  brk_level;
    logic [5:0]  brk_vec;
    logic [31:0] dev_grant;
    logic [7:0]  in_service;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    prio_vec_intc i_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .pwr_clr(pwr_clr), .en_cmd_valid(en_cmd_valid),
        .en_cmd_value(en_cmd_value), .dev_req(dev_req), .sw_set(sw_set),
        .brk_ack(brk_ack), .dismiss(dismiss), .dev_vec_in(dev_vec_in),
        .brk_req(brk_req), .vec_valid(vec_valid), .brk_level(brk_level),
        .brk_vec(brk_vec), .dev_grant(dev_grant), .in_service(in_service)
    );

    // device side: the granted device posts vector 0o40 + channel
    always_comb begin
        dev_vec_in = '0;
        for (int c = 0; c < CH; c++) if (dev_grant[c]) dev_vec_in = 6'(32 + c);
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_en;
    bit [3:0] m_sw;
    bit [7:0] m_is;
    bit       m_vv;
    int       m_lvl;
    int       m_ch;

    function automatic int top_of(bit [7:0] v);
        for (int i = 0; i < LV; i++) if (v[i]) return i;
        return LV;
    endfunction

    function automatic int pend_top();
        for (int l = 0; l < LV; l++) begin
            if (l < HWL) begin
                if (dev_req[l*SL +: SL] != 0) return l;
            end else if (m_sw[l-HWL]) return l;
        end
        return LV;
    endfunction

    function automatic bit m_req();
        return m_en && (pend_top() < top_of(m_is));
    endfunction

    always @(posedge clk) begin
        if (!rst_n || pwr_clr) begin
            m_en = 0; m_sw = 0; m_is = 0; m_vv = 0; m_lvl = 0; m_ch = -1;
        end else begin
            bit g;
            int p, lo;
            g  = brk_ack && m_req();
            p  = pend_top();
            lo = top_of(m_is);
            if (dismiss && lo < LV) m_is[lo] = 0;
            if (g) m_is[p] = 1;
            if (g && p >= HWL) m_sw[p-HWL] = 0;
            m_sw = m_sw | sw_set;
            if (en_cmd_valid) m_en = en_cmd_value;
            m_vv = g;
            if (g) begin
                m_lvl = p;
                m_ch  = -1;
                if (p < HWL)
                    for (int d = SL - 1; d >= 0; d--) if (dev_req[p*SL + d]) m_ch = p*SL + d;
            end
        end
    end

    // compare every output against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] eg;
            eg = '0;
            if (m_vv && m_ch >= 0) eg[m_ch] = 1'b1;
            chk(brk_req === m_req(), "R4 brk_req", brk_req, m_req());
            chk(in_service === m_is, "R5 in_service", in_service, m_is);
            chk(vec_valid === m_vv, "R5 vec_valid", vec_valid, m_vv);
            chk(dev_grant === eg, "R6 dev_grant", dev_grant, eg);
            if (m_vv) begin
                logic [5:0] ev;
                ev = (m_ch >= 0) ? 6'(32 + m_ch) : 6'('o74 + m_lvl - HWL);
                chk(brk_level === 3'(m_lvl), "R3 brk_level", brk_level, m_lvl);
                chk(brk_vec === ev, "R7 brk_vec", brk_vec, ev);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #5;
            dev_req = dev_req & ~dev_grant;
        end
    endtask

    task automatic do_ack();  brk_ack = 1; step(); brk_ack = 0; endtask
    task automatic do_dis();  dismiss = 1; step(); dismiss = 0; endtask
    task automatic do_en(input bit v);
        en_cmd_valid = 1; en_cmd_value = v; step(); en_cmd_valid = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk);
        chk(in_service == 0, "R1 reset in_service", in_service, 0);
        chk(brk_req == 0, "R1 reset brk_req", brk_req, 0);

        dev_req[19] = 1; dev_req[21] = 1; step(); @(negedge clk);
        chk(brk_req == 0, "R2 disabled", brk_req, 0);
        do_en(1); @(negedge clk);
        chk(brk_req == 1, "R4 request", brk_req, 1);
        do_ack(); @(negedge clk);
        chk(dev_grant == 32'h1 << 19, "R6 chain order", dev_grant, 32'h1 << 19);
        chk(brk_vec == 6'o63, "R7 hw vector", brk_vec, 6'o63);
        chk(in_service == 8'h04, "R5 in-service", in_service, 8'h04);

        dev_req[2] = 1; step(); @(negedge clk);
        chk(brk_req == 1, "R9 preempt request", brk_req, 1);
        do_ack(); @(negedge clk);
        chk(in_service == 8'h05, "R9 nested", in_service, 8'h05);
        chk(brk_vec == 6'o42, "R9 vector", brk_vec, 6'o42);

        sw_set[1] = 1; step(); sw_set = 0; @(negedge clk);
        chk(brk_req == 0, "R3 sw below service", brk_req, 0);
        do_dis(); @(negedge clk);
        chk(in_service == 8'h04, "R8 dismiss top", in_service, 8'h04);
        do_ack(); @(negedge clk);
        chk(vec_valid == 0, "R10 ack ignored", vec_valid, 0);
        chk(in_service == 8'h04, "R10 unchanged", in_service, 8'h04);

        dev_req[9] = 1; step();
        brk_ack = 1; dismiss = 1; step(); brk_ack = 0; dismiss = 0; @(negedge clk);
        chk(in_service == 8'h02, "R11 ack+dismiss", in_service, 8'h02);
        chk(brk_vec == 6'o51, "R11 vector", brk_vec, 6'o51);

        do_dis(); @(negedge clk);
        chk(in_service == 0, "R8 empty", in_service, 0);
        do_ack(); @(negedge clk);
        chk(dev_grant == 32'h1 << 21, "R6 second slot", dev_grant, 32'h1 << 21);
        do_dis(); do_ack(); @(negedge clk);
        chk(brk_vec == 6'o75, "R7 sw vector", brk_vec, 6'o75);
        chk(dev_grant == 0, "R7 no strobe", dev_grant, 0);
        chk(in_service == 8'h20, "R7 sw in-service", in_service, 8'h20);
        do_dis(); @(negedge clk);
        chk(brk_req == 0, "R7 sw pending consumed", brk_req, 0);
        do_dis(); @(negedge clk);
        chk(in_service == 0, "R8 dismiss when idle", in_service, 0);

        en_cmd_valid = 1; en_cmd_value = 0; sw_set[3] = 1; step();
        en_cmd_valid = 0; sw_set = 0; @(negedge clk);
        chk(brk_req == 0, "R2 off keeps quiet", brk_req, 0);
        do_en(1); @(negedge clk);
        chk(brk_req == 1, "R2 pending kept", brk_req, 1);
        pwr_clr = 1; step(); pwr_clr = 0;
        sw_set[0] = 1; step(); sw_set = 0; @(negedge clk);
        chk(brk_req == 0, "R1 enable cleared", brk_req, 0);
        do_en(1); @(negedge clk);
        do_ack(); @(negedge clk);
        chk(brk_vec == 6'o74, "R7 sw level 4 vector", brk_vec, 6'o74);
        do_dis(); @(negedge clk);
        chk(brk_req == 0, "R1 sw pending cleared", brk_req, 0);

        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 6 == 0) dev_req[$urandom % 28] = 1;
            brk_ack      = ($urandom % 3 == 0);
            dismiss      = ($urandom % 5 == 0);
            sw_set       = ($urandom % 9 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
            en_cmd_valid = ($urandom % 40 == 0);
            en_cmd_value = ($urandom % 4 != 0);
            pwr_clr      = ($urandom % 600 == 0);
            step();
        end
        brk_ack = 0; dismiss = 0; sw_set = 0; en_cmd_valid = 0; pwr_clr = 0;
        step(2);
        finish_run();
    end
endmodule